// File: doc/BRIEF.md
# Programmable Clock Divider with Duty Control

This block derives a slower clock from its input clock by counting input cycles. A divide field sets the period length and a separate high-time field sets how many input cycles of each period the output spends high. A mode input chooses how both fields are coded. In zero-based coding a field value of v means v+1. In one-based coding a field value means v. A divide field of zero switches the output off and holds it low.

New settings are presented on the field inputs and captured with a single-cycle load strobe. The captured settings wait in a pending stage and replace the running settings only when the current period ends. The output therefore never shows a shortened high or low phase when the settings change. The output comes directly from a register, so it carries no combinational glitches.

Top module: `clk_div_duty`

## Requirements
- R1: When the active divide field is zero, clk_o is held low for as long as that setting stays active. A divide value of zero that is loaded while the divider is running takes effect at the end of the current period.
- R2: With one_based_i=0 and a divide field v≥1, clk_o repeats with a period of v+1 input cycles.
- R3: With one_based_i=1 and a divide field v≥1, clk_o repeats with a period of exactly v input cycles.
- R4: With one_based_i=0 and a high-time field h, clk_o is high for the first h+1 input cycles of each period and low for the rest.
- R5: With one_based_i=1 and a high-time field h, clk_o is high for the first h input cycles of each period. When h=0, clk_o stays low.
- R6: When the decoded high time is equal to or greater than the decoded period, clk_o stays high continuously.
- R7: The smallest period is 2 cycles with one_based_i=0 (v=1) and 1 cycle with one_based_i=1 (v=1). The largest period is 2^DIV_W cycles with one_based_i=0 and 2^DIV_W−1 cycles with one_based_i=1.
- R8: The fields and the mode are captured only on a cycle with load_i=1. Changes on div_i, hi_i and one_based_i without load_i have no effect. A captured setting replaces the running one only after the last cycle of the current period, so every period runs to its full length.
- R9: While rst_ni is low, clk_o is low. After reset the divider is stopped, as if a divide value of zero were loaded.
- R10: When the divider is stopped and load_i is sampled high at rising edge E, the new period starts at rising edge E+1. clk_o is high after E+1 if the decoded high time is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Divide field; 0 stops the output |
| hi_i | input | HI_W | High-time field |
| one_based_i | input | 1 | 1 selects one-based coding of both fields, 0 selects zero-based coding |
| load_i | input | 1 | Capture strobe for div_i, hi_i and one_based_i |
| clk_o | output | 1 | Divided clock output |

## Verification
The bench checks the edges of the coding. One-based v=1 gives a continuous output, and a design that subtracts one from the count would stall or wrap instead. Zero-based v=1 gives a strict alternation. The all-ones field gives the longest periods, and a design with a counter one bit too narrow would wrap early. High times equal to or beyond the period must produce a steady high, and a one-based high time of zero must produce a steady low; a wrong comparison would let a single-cycle pulse slip out in either case. Settings are loaded in the middle of a period, and a design that applies them at once would show a clipped phase. Fields are also changed without a strobe, which a design that samples its inputs directly would follow. The bench also loads a divide of zero while the divider runs, and resets the block in the middle of a period.

// File: rtl/clk_div_duty_pkg.sv
package clk_div_duty_pkg;
  typedef enum logic {
    CODE_ZERO = 1'b0,
    CODE_ONE  = 1'b1
  } code_e;
endpackage

// File: rtl/clk_div_duty_decode.sv
module clk_div_duty_decode
  import clk_div_duty_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int HI_W  = 8,
  localparam int CW   = ((DIV_W > HI_W) ? DIV_W : HI_W) + 1
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic [HI_W-1:0]  hi_i,
  input  code_e            mode_i,
  output logic [CW-1:0]    ratio_o,
  output logic [CW-1:0]    hcnt_o
);
  always_comb begin
    if (div_i == '0)             ratio_o = '0;
    else if (mode_i == CODE_ONE) ratio_o = CW'(div_i);
    else                         ratio_o = CW'(div_i) + CW'(1);
    hcnt_o = (mode_i == CODE_ONE) ? CW'(hi_i) : CW'(hi_i) + CW'(1);
  end
endmodule

// File: rtl/clk_div_duty_cfg.sv
module clk_div_duty_cfg
  import clk_div_duty_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int HI_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [HI_W-1:0]  hi_i,
  input  code_e            mode_i,
  input  logic             wrap_i,
  output logic [DIV_W-1:0] act_div_o,
  output logic [HI_W-1:0]  act_hi_o,
  output code_e            act_mode_o,
  output logic [DIV_W-1:0] pend_div_o,
  output logic [HI_W-1:0]  pend_hi_o,
  output code_e            pend_mode_o,
  output logic             apply_o
);
  logic pend_v_q;

  assign apply_o = pend_v_q && wrap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q    <= 1'b0;
      pend_div_o  <= '0;
      pend_hi_o   <= '0;
      pend_mode_o <= CODE_ZERO;
      act_div_o   <= '0;
      act_hi_o    <= '0;
      act_mode_o  <= CODE_ZERO;
    end else begin
      if (load_i) begin
        pend_v_q    <= 1'b1;
        pend_div_o  <= div_i;
        pend_hi_o   <= hi_i;
        pend_mode_o <= mode_i;
      end else if (apply_o) begin
        pend_v_q <= 1'b0;
      end
      if (apply_o) begin
        act_div_o  <= pend_div_o;
        act_hi_o   <= pend_hi_o;
        act_mode_o <= pend_mode_o;
      end
    end
  end

  // R8: running setting only moves on an apply
  a_r8_hold_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_o |=> ($stable(act_div_o) && $stable(act_hi_o) && $stable(act_mode_o)));
endmodule

// File: rtl/clk_div_duty_core.sv
module clk_div_duty_core #(
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] ratio_i,
  input  logic [CW-1:0] hcnt_i,
  input  logic [CW-1:0] new_ratio_i,
  input  logic [CW-1:0] new_hcnt_i,
  input  logic          apply_i,
  output logic          wrap_o,
  output logic          clk_o
);
  logic [CW-1:0] cnt_q, cnt_nxt;

  assign wrap_o  = (ratio_i == '0) || (cnt_q == ratio_i - CW'(1));
  assign cnt_nxt = wrap_o ? '0 : cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_o <= 1'b0;
    end else if (apply_i) begin
      cnt_q <= '0;
      clk_o <= (new_ratio_i != '0) && (new_hcnt_i != '0);
    end else if (ratio_i == '0) begin
      cnt_q <= '0;
      clk_o <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      clk_o <= cnt_nxt < hcnt_i;
    end
  end

  a_r1_gated_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i == '0 && !apply_i) |=> !clk_o);
  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i != '0) |-> (cnt_q < ratio_i));
  a_r6_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i != '0 && hcnt_i >= ratio_i && !apply_i) |=> clk_o);
  a_r8_apply_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |-> (ratio_i == '0 || cnt_q == ratio_i - CW'(1)));
endmodule

// File: rtl/clk_div_duty.sv
module clk_div_duty
  import clk_div_duty_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int HI_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [HI_W-1:0]  hi_i,
  input  logic             one_based_i,
  input  logic             load_i,
  output logic             clk_o
);
  localparam int CW = ((DIV_W > HI_W) ? DIV_W : HI_W) + 1;

  logic [DIV_W-1:0] act_div, pend_div;
  logic [HI_W-1:0]  act_hi, pend_hi;
  code_e            act_mode, pend_mode;
  logic [CW-1:0]    ratio, hcnt, new_ratio, new_hcnt;
  logic             wrap, apply;

  clk_div_duty_cfg #(.DIV_W(DIV_W), .HI_W(HI_W)) u_cfg (
    .clk_i, .rst_ni, .load_i, .div_i, .hi_i,
    .mode_i(code_e'(one_based_i)), .wrap_i(wrap),
    .act_div_o(act_div), .act_hi_o(act_hi), .act_mode_o(act_mode),
    .pend_div_o(pend_div), .pend_hi_o(pend_hi), .pend_mode_o(pend_mode),
    .apply_o(apply)
  );

  clk_div_duty_decode #(.DIV_W(DIV_W), .HI_W(HI_W)) u_dec_act (
    .div_i(act_div), .hi_i(act_hi), .mode_i(act_mode),
    .ratio_o(ratio), .hcnt_o(hcnt)
  );

  clk_div_duty_decode #(.DIV_W(DIV_W), .HI_W(HI_W)) u_dec_pend (
    .div_i(pend_div), .hi_i(pend_hi), .mode_i(pend_mode),
    .ratio_o(new_ratio), .hcnt_o(new_hcnt)
  );

  clk_div_duty_core #(.CW(CW)) u_core (
    .clk_i, .rst_ni, .ratio_i(ratio), .hcnt_i(hcnt),
    .new_ratio_i(new_ratio), .new_hcnt_i(new_hcnt),
    .apply_i(apply), .wrap_o(wrap), .clk_o
  );

  // R9: output low under reset
  always @(posedge clk_i) begin
    if (!rst_ni) a_r9_reset_low: assert (clk_o == 1'b0);
  end
endmodule

// File: tb/clk_div_duty_tb_top.sv
module clk_div_duty_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] div_i = '0;
  logic [7:0] hi_i = '0;
  logic       one_based_i = 1'b0;
  logic       load_i = 1'b0;
  logic       clk_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  clk_div_duty #(.DIV_W(8), .HI_W(8)) dut_i (
    .clk_i, .rst_ni, .div_i, .hi_i, .one_based_i, .load_i, .clk_o
  );

  int    n_run = 0, n_fail = 0;
  bit    done = 0;
  bit    q_exp[$];
  string q_req[$];
  int    m_r = 0, m_h = 0, m_k = 0, p_r = 0, p_h = 0;
  bit    pend = 0;

  function automatic int f_ratio(int d, bit ob);
    if (d == 0) return 0;
    return ob ? d : d + 1;
  endfunction
  function automatic int f_high(int h, bit ob);
    return ob ? h : h + 1;
  endfunction

  task automatic check(bit act, bit exp, string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: clk_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: predict output after the coming rising edge, then step
  task automatic cyc(string req);
    bit wrap, app;
    wrap = (m_r == 0) || (m_k == m_r - 1);
    app  = pend && wrap;
    if (app) begin m_r = p_r; m_h = p_h; m_k = 0; end
    else if (m_r == 0) m_k = 0;
    else m_k = wrap ? 0 : m_k + 1;
    if (load_i) begin
      pend = 1; p_r = f_ratio(int'(div_i), one_based_i); p_h = f_high(int'(hi_i), one_based_i);
    end else if (app) pend = 0;
    q_exp.push_back((m_r != 0) && (m_k < m_h));
    q_req.push_back(req);
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic run(int n, string req);
    repeat (n) cyc(req);
  endtask

  task automatic load(int d, int h, bit ob, string req);
    div_i = 8'(d); hi_i = 8'(h); one_based_i = ob; load_i = 1'b1;
    cyc(req);
    load_i = 1'b0;
  endtask

  task automatic do_reset(int n);
    rst_ni = 1'b0; m_r = 0; m_k = 0; pend = 0;
    repeat (n) begin
      @(negedge clk_i);
      check(clk_o, 1'b0, "R9");
    end
    rst_ni = 1'b1;
  endtask

  // monitor: scoreboard compare after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #5;
      if (q_exp.size() > 0) begin
        bit    e;
        string t;
        e = q_exp.pop_front();
        t = q_req.pop_front();
        check(clk_o, e, t);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run state=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(4);
    run(4, "R9");                         // stopped after reset
    load(3, 1, 1'b0, "R10"); run(12, "R2"); // period 4, high 2
    do_reset(2);
    load(3, 1, 1'b0, "R4"); run(12, "R4");
    do_reset(2);
    load(5, 2, 1'b1, "R3"); run(15, "R3");  // period 5, high 2
    load(4, 0, 1'b1, "R5"); run(12, "R5");  // one-based h=0 -> low
    load(6, 3, 1'b1, "R5"); run(14, "R5");
    load(2, 5, 1'b0, "R6"); run(10, "R6");
    load(3, 3, 1'b1, "R6"); run(10, "R6");
    load(1, 0, 1'b0, "R7"); run(10, "R7");  // period 2
    load(1, 1, 1'b1, "R7"); run(10, "R7");  // period 1
    load(255, 127, 1'b0, "R7"); run(560, "R7");
    load(255, 10, 1'b1, "R7"); run(530, "R7");
    // reload mid-period
    load(4, 1, 1'b0, "R8"); run(7, "R8");
    load(3, 2, 1'b1, "R8"); run(12, "R8");
    div_i = 8'd1; hi_i = 8'd0; one_based_i = 1'b0;  // no strobe
    run(12, "R8");
    load(0, 0, 1'b0, "R1"); run(12, "R1");
    load(2, 0, 1'b0, "R10"); run(6, "R10");
    do_reset(3);                           // reset mid-period
    run(5, "R9");
    load(3, 0, 1'b1, "R9"); run(9, "R9");
    run(2, "R9");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule